// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

The block holds a 32-bit up-counter and a 32-bit compare register for a processor's control-register set. Each tick pulse from a 100 MHz timebase, one tick per 10 ns, advances the counter by one. The counter wraps modulo 2^32. Software may load the counter at any time, and counting continues from the loaded value. A hold input freezes the counter. While it is asserted, no new match can occur.

A match is the counter stepping by a tick onto the compare value. It raises a level interrupt on one of eight output lines, chosen by a 3-bit selector. The interrupt stays high until software writes the compare register. A pending status bit follows the same set and clear rules, but it is set only when the revision-2 feature input is high. The bus decode that produces the write strobes is outside the block, and so is the interrupt controller that receives the line vector.

Top module: `cp_timer`

## Requirements
- R1: With `cnt_hold_i` low and no counter write, each cycle with `tick_i` high raises `count_o` by one in the next cycle, and 32'hFFFFFFFF wraps to 0.
- R2: While `cnt_hold_i` is high, ticks leave `count_o` unchanged and cannot start a new interrupt.
- R3: `cnt_we_i` loads `cnt_wdata_i` into the counter in the next cycle, even when a tick or hold is present in the same cycle. Counting then resumes from the loaded value. A load never counts as a match.
- R4: A tick that moves the counter onto the compare value raises bit `irq_sel_i` of `irq_o` in the next cycle. The line stays high while no compare write occurs.
- R5: The same match sets `pending_o` in the next cycle only if `rev2_i` is high in the match cycle. Otherwise `pending_o` stays low.
- R6: `cmp_we_i` stores `cmp_wdata_i` and clears `irq_o` to 0 and `pending_o` to 0 in the next cycle.
- R7: At most one bit of `irq_o` is high, and it is always bit `irq_sel_i` (bit n for selector value n). Changing the selector while the interrupt is active moves it to the new line in the same cycle.
- R8: A compare write in the same cycle as a match leaves `irq_o` and `pending_o` at 0.
- R9: After reset, `count_o`, `pending_o` and `irq_o` are 0, and the compare register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick, one pulse per count step |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write data |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 32 | Compare write data |
| cnt_hold_i | input | 1 | Freeze counting when high |
| irq_sel_i | input | 3 | Interrupt line selector |
| rev2_i | input | 1 | Enables the pending status bit |
| count_o | output | 32 | Current counter value |
| pending_o | output | 1 | Timer pending status |
| irq_o | output | 8 | Interrupt line vector |

## Verification
The assertions assume that the write strobes and the tick are single-cycle levels that are valid at the clock edge. They also assume that `irq_sel_i` and `rev2_i` may change in any cycle without affecting the counter. The stimulus drives every input only on the falling edge, so each vector holds one stable input set across exactly one rising edge. The vectors include a tick together with a load, a tick together with a hold, and a compare write in the same cycle as a match, so that the priority of each write over the count or the match is exercised.

// File: rtl/cp_timer.sv
module cp_timer #(
  parameter int CW    = 32,
  parameter int LINES = 8,
  localparam int SW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          cmp_we_i,
  input  logic [CW-1:0] cmp_wdata_i,
  input  logic          cnt_hold_i,
  input  logic [SW-1:0] irq_sel_i,
  input  logic          rev2_i,
  output logic [CW-1:0] count_o,
  output logic          pending_o,
  output logic [LINES-1:0] irq_o
);

  logic [CW-1:0] cnt_q, cmp_q, cnt_inc;
  logic          step, hit, hit_q, pend_q;

  assign step    = tick_i && !cnt_hold_i && !cnt_we_i;
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = step && (cnt_inc == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_we_i)  cnt_q <= cnt_wdata_i;
      else if (step) cnt_q <= cnt_inc;
      if (cmp_we_i)  cmp_q <= cmp_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (cmp_we_i) begin
      hit_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (hit) begin
      hit_q  <= 1'b1;
      pend_q <= pend_q | rev2_i;
    end
  end

  assign count_o   = cnt_q;
  assign pending_o = pend_q;
  assign irq_o     = hit_q ? (LINES'(1) << irq_sel_i) : '0;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_hold_i && !cnt_we_i) |=> (count_o == $past(count_o) + 1'b1));

  assert_hold_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hold_i && !cnt_we_i) |=> $stable(count_o));

  assert_hold_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hold_i |=> !$rose(irq_o != '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (count_o == $past(cnt_wdata_i)));

  assert_pend_needs_rev2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_o) |-> $past(rev2_i));

  assert_cmp_clears_R6_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i |=> (irq_o == '0 && !pending_o));

  assert_irq_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o) && ((irq_o == '0) || irq_o[irq_sel_i]));

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o != '0) && !cmp_we_i) |=> (irq_o != '0));

endmodule

// File: tb/sim_cp_timer.sv
module sim_cp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, cnt_we_i, cmp_we_i, cnt_hold_i, rev2_i;
  logic [31:0] cnt_wdata_i, cmp_wdata_i;
  logic [2:0]  irq_sel_i;
  logic [31:0] count_o;
  logic        pending_o;
  logic [7:0]  irq_o;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cp_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_we_i(cnt_we_i),
    .cnt_wdata_i(cnt_wdata_i), .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .cnt_hold_i(cnt_hold_i), .irq_sel_i(irq_sel_i), .rev2_i(rev2_i),
    .count_o(count_o), .pending_o(pending_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        tk;
    logic        cw;
    logic [31:0] cd;
    logic        kw;
    logic [31:0] kd;
    logic        hold;
    logic [2:0]  sel;
    logic        rev;
    logic [31:0] ecnt;
    logic        epend;
    logic [7:0]  eirq;
  } vec_t;

  function automatic vec_t mk(logic tk, logic cw, logic [31:0] cd, logic kw,
                              logic [31:0] kd, logic hold, logic [2:0] sel,
                              logic rev, logic [31:0] ecnt, logic epend,
                              logic [7:0] eirq);
    return '{tk, cw, cd, kw, kd, hold, sel, rev, ecnt, epend, eirq};
  endfunction

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    mk(0,1,2,1,5,0,2,1, 2,0,8'h00),            // R3 R6 load count and compare
    mk(1,0,0,0,0,0,2,1, 3,0,8'h00),            // R1
    mk(1,0,0,0,0,0,2,1, 4,0,8'h00),            // R1
    mk(1,0,0,0,0,0,2,1, 5,1,8'h04),            // R4 R5 match on line 2
    mk(0,0,0,0,0,0,5,1, 5,1,8'h20),            // R7 selector moves line
    mk(1,0,0,0,0,0,5,1, 6,1,8'h20),            // R4 level held
    mk(0,0,0,1,8,0,5,1, 6,0,8'h00),            // R6 compare write clears
    mk(1,0,0,0,0,1,5,1, 6,0,8'h00),            // R2 hold
    mk(1,0,0,0,0,0,5,1, 7,0,8'h00),            // R1 resume
    mk(1,0,0,0,0,1,5,1, 7,0,8'h00),            // R2 held tick at compare-1, no match
    mk(0,1,8,0,0,1,5,1, 8,0,8'h00),            // R3 load onto compare while held: no match
    mk(1,0,0,0,0,0,5,1, 9,0,8'h00),            // R3 counts on from loaded value
    mk(0,1,32'hFFFFFFFF,1,1,0,5,0, 32'hFFFFFFFF,0,8'h00), // R3
    mk(1,0,0,0,0,0,5,0, 0,0,8'h00),            // R1 wrap
    mk(1,0,0,0,0,0,5,0, 1,0,8'h20),            // R5 match without rev2: no pending
    mk(0,0,0,0,0,0,7,0, 1,0,8'h80),            // R7 line 7
    mk(0,0,0,1,3,0,7,1, 1,0,8'h00),            // R6
    mk(1,0,0,0,0,0,7,1, 2,0,8'h00),            // R1
    mk(1,0,0,1,9,0,7,1, 3,0,8'h00),            // R8 write beats match
    mk(1,1,100,0,0,0,7,1, 100,0,8'h00),        // R3 load beats tick
    mk(1,0,0,0,0,0,7,1, 101,0,8'h00),          // R1
    mk(0,1,8,0,0,0,0,1, 8,0,8'h00),            // R3
    mk(1,0,0,0,0,0,0,1, 9,1,8'h01)             // R4 R5 match on line 0
  };

  task automatic check(string tag, logic [31:0] ecnt, logic epend, logic [7:0] eirq);
    applied++;
    if (count_o !== ecnt || pending_o !== epend || irq_o !== eirq) begin
      bad++;
      $display("FAIL %s: count=%h pend=%b irq=%h expected count=%h pend=%b irq=%h",
               tag, count_o, pending_o, irq_o, ecnt, epend, eirq);
    end
  endtask

  task automatic idle();
    tick_i = 0; cnt_we_i = 0; cmp_we_i = 0; cnt_hold_i = 0;
    cnt_wdata_i = 0; cmp_wdata_i = 0;
  endtask

  initial begin
    idle(); irq_sel_i = 0; rev2_i = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9 reset", 32'd0, 1'b0, 8'h00);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      tick_i = VECS[i].tk; cnt_we_i = VECS[i].cw; cnt_wdata_i = VECS[i].cd;
      cmp_we_i = VECS[i].kw; cmp_wdata_i = VECS[i].kd; cnt_hold_i = VECS[i].hold;
      irq_sel_i = VECS[i].sel; rev2_i = VECS[i].rev;
      @(negedge clk);
      check($sformatf("vector %0d", i), VECS[i].ecnt, VECS[i].epend, VECS[i].eirq);
    end
    idle();
    // R9: reset in mid-run returns everything to zero, compare to 0
    rst_n = 0;
    @(negedge clk);
    check("R9 mid-run reset", 32'd0, 1'b0, 8'h00);
    rst_n = 1; irq_sel_i = 3;
    cnt_we_i = 1; cnt_wdata_i = 32'hFFFFFFFF;
    @(negedge clk);
    idle(); tick_i = 1;
    @(negedge clk);
    check("R9 compare reset to 0 (wrap match)", 32'd0, 1'b1, 8'h08);
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule